// File: doc/BRIEF.md
# Overtemperature and register-integrity alarm monitor

This block watches a digital die-temperature reading and the contents of the configuration register file. It raises a single active-low alarm line for three kinds of fault: a warm die, a die hot enough to force every output channel off, and a configuration register whose bits have changed without a legitimate write.

Temperature is a whole number of degrees Celsius, taken every clock. Two thresholds act differently. The lower one only warns. The upper one also latches a force-off command towards the register controller. That latch releases only once the die has cooled past a separate rearm point and software has cleared the shutdown status bit.

Register integrity is checked in the background with CRC-8. Every write-done pulse starts a recompute of the reference checksum. A timer starts a fresh check pass at a fixed interval and compares its result with that reference. Status bits are sticky and clear on read, and a bit cannot clear while its cause is still present.

Top module: `thermal_integrity_alarm`

## Requirements
- R1: A temperature of 125 or more sets status bit 0 (warning). 124 leaves it clear. Status and alarm respond on the second rising edge after the temperature input changes.
- R2: A temperature of 150 or more sets status bit 1 (shutdown) and drives every bit of `force_off` high.
- R3: Once set, `force_off` stays high until two conditions hold together: the registered temperature is below 140, and status bit 1 is clear. A temperature from 140 to 149 never releases it.
- R4: A `stat_rd` pulse clears the status bits on the following edge, except those whose cause is present in that cycle. With no read, a set bit stays set after its cause goes away.
- R5: `alarm_n` is low exactly when any status bit is set, and it changes in the same cycle as the status bits.
- R6: The checksum is CRC-8, polynomial 0x07, initial value 0x00, shifted MSB first. Byte 0 is `regs_flat[7:0]` and is taken first. A `reg_wr_done` pulse makes the block recompute and store the reference from the new contents, so register changes that come with that pulse never raise a fault.
- R7: A check pass starts every CHECK_PERIOD cycles (1024 by default). A check result that differs from the reference sets status bit 2 within CHECK_PERIOD+NUM_BYTES+8 cycles of the change. Changed contents that give the same CRC raise no fault.
- R8: A CRC mismatch stays a present cause until a later pass matches or the reference is recomputed. Until then a read does not clear status bit 2.
- R9: After reset, `status_q` is 0, `alarm_n` is 1 and `force_off` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| temp_c | input | TEMP_W | Die temperature, unsigned degrees Celsius |
| regs_flat | input | NUM_BYTES*8 | Configuration register contents, byte 0 in the low bits |
| reg_wr_done | input | 1 | One-cycle pulse after a legitimate register write |
| stat_rd | input | 1 | Status read strobe, clears bits whose cause is gone |
| status_q | output | 3 | Sticky status: bit 0 warning, bit 1 shutdown, bit 2 CRC fault |
| alarm_n | output | 1 | Active-low alarm, OR of the status bits |
| force_off | output | NUM_CH | Force-off command, one bit per output channel |

## Verification
Directed temperature steps probe each threshold from both sides: 124 against 125, 149 against 150, and 140 against 139 for rearm. Reads are issued both while the cause is present and after it has gone, which separates a sticky bit from one that simply follows the input. A long random walk of temperatures between 110 and 165, with reads on about a quarter of the cycles, is compared cycle by cycle against a bench model of the sticky bits and the shutdown latch.

On the integrity side, written changes must stay silent and a single flipped bit must raise a fault. A two-byte change built in the bench to give the same CRC-8 must also stay silent, which only holds if the checksum arithmetic and the byte order are right. Restoring the original contents must let the fault clear on read.

// File: rtl/tia_pkg.sv
package tia_pkg;

  localparam int ST_W    = 3;
  localparam int ST_WARN = 0;
  localparam int ST_SHUT = 1;
  localparam int ST_CRC  = 2;

  localparam logic [7:0] CRC_POLY = 8'h07;

  typedef enum logic {PASS_REF = 1'b0, PASS_CHK = 1'b1} pass_e;

  // One byte of CRC-8, MSB first, no reflection
  function automatic logic [7:0] crc8_byte(input logic [7:0] acc, input logic [7:0] din);
    logic [7:0] x;
    x = acc ^ din;
    for (int i = 0; i < 8; i++) begin
      x = x[7] ? ((x << 1) ^ CRC_POLY) : (x << 1);
    end
    return x;
  endfunction

endpackage

// File: rtl/tia_thermal.sv
module tia_thermal #(
  parameter int TEMP_W  = 8,
  parameter int WARN_C  = 125,
  parameter int SHUT_C  = 150,
  parameter int REARM_C = 140
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TEMP_W-1:0] temp_c,
  output logic              warn_hot,
  output logic              shut_hot,
  output logic              cool_enough
);

  localparam logic [TEMP_W-1:0] WARN_T  = TEMP_W'(WARN_C);
  localparam logic [TEMP_W-1:0] SHUT_T  = TEMP_W'(SHUT_C);
  localparam logic [TEMP_W-1:0] REARM_T = TEMP_W'(REARM_C);

  logic [TEMP_W-1:0] temp_q;

  always_ff @(posedge clk) begin
    if (rst) temp_q <= '0;
    else     temp_q <= temp_c;
  end

  assign warn_hot    = (temp_q >= WARN_T);
  assign shut_hot    = (temp_q >= SHUT_T);
  assign cool_enough = (temp_q <  REARM_T);

endmodule

// File: rtl/tia_crc_engine.sv
module tia_crc_engine #(
  parameter int NUM_BYTES = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic [NUM_BYTES*8-1:0] vec,
  output logic                   busy,
  output logic                   done,
  output logic [7:0]             crc
);
  import tia_pkg::*;

  localparam int VEC_W = NUM_BYTES * 8;
  localparam int IDX_W = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_BYTES - 1);

  logic [VEC_W-1:0] snap;
  logic [IDX_W-1:0] idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      snap <= '0;
      idx  <= '0;
      crc  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        snap <= vec;
        idx  <= '0;
        crc  <= '0;
        busy <= 1'b1;
      end else if (busy) begin
        crc <= crc8_byte(crc, snap[int'(idx)*8 +: 8]);
        if (idx == LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end

  // R6: a pass is launched only while the engine is idle
  a_r6_start_when_idle: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy);

  // R6: completion only ends a running pass
  a_r6_done_after_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(busy));

endmodule

// File: rtl/tia_crc_sched.sv
module tia_crc_sched #(
  parameter int CHECK_PERIOD = 1024
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       reg_wr_done,
  input  logic       eng_busy,
  input  logic       eng_done,
  input  logic [7:0] eng_crc,
  output logic       start,
  output logic       crc_mismatch
);
  import tia_pkg::*;

  localparam int CNT_W = (CHECK_PERIOD > 1) ? $clog2(CHECK_PERIOD) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CHECK_PERIOD - 1);

  logic [CNT_W-1:0] cnt;
  logic             tick;
  logic             pend_ref, pend_chk, discard, ref_valid;
  logic [7:0]       ref_q;
  pass_e            mode;
  logic             want_ref, start_ref, start_chk, drop_result;

  assign tick        = (cnt == CNT_LAST);
  assign want_ref    = pend_ref | reg_wr_done;
  assign start_ref   = !eng_busy && want_ref;
  assign start_chk   = !eng_busy && !want_ref && pend_chk && ref_valid;
  assign start       = start_ref | start_chk;
  assign drop_result = discard | reg_wr_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt          <= '0;
      pend_ref     <= 1'b1;
      pend_chk     <= 1'b0;
      discard      <= 1'b0;
      ref_valid    <= 1'b0;
      ref_q        <= '0;
      mode         <= PASS_REF;
      crc_mismatch <= 1'b0;
    end else begin
      cnt <= tick ? '0 : cnt + 1'b1;

      if (tick)           pend_chk <= 1'b1;
      else if (start_chk) pend_chk <= 1'b0;

      if (start_ref)        pend_ref <= 1'b0;
      else if (reg_wr_done) pend_ref <= 1'b1;

      if (start)                        discard <= 1'b0;
      else if (reg_wr_done && eng_busy) discard <= 1'b1;

      if (start) mode <= start_ref ? PASS_REF : PASS_CHK;

      if (eng_done && !drop_result) begin
        if (mode == PASS_REF) begin
          ref_q        <= eng_crc;
          ref_valid    <= 1'b1;
          crc_mismatch <= 1'b0;
        end else begin
          crc_mismatch <= (eng_crc != ref_q);
        end
      end
    end
  end

  // R7: a fault is only ever reported at the end of a pass
  a_r7_fault_from_pass: assert property (@(posedge clk) disable iff (rst)
    $rose(crc_mismatch) |-> $past(eng_done));

  // R6: a write pulse in an idle cycle starts a reference pass at once
  a_r6_write_restarts: assert property (@(posedge clk) disable iff (rst)
    (reg_wr_done && !eng_busy) |=> eng_busy);

endmodule

// File: rtl/thermal_integrity_alarm.sv
module thermal_integrity_alarm #(
  parameter int TEMP_W       = 8,
  parameter int WARN_C       = 125,
  parameter int SHUT_C       = 150,
  parameter int REARM_C      = 140,
  parameter int NUM_CH       = 6,
  parameter int NUM_BYTES    = 8,
  parameter int CHECK_PERIOD = 1024
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [TEMP_W-1:0]      temp_c,
  input  logic [NUM_BYTES*8-1:0] regs_flat,
  input  logic                   reg_wr_done,
  input  logic                   stat_rd,
  output logic [2:0]             status_q,
  output logic                   alarm_n,
  output logic [NUM_CH-1:0]      force_off
);
  import tia_pkg::*;

  logic             warn_hot, shut_hot, cool_enough;
  logic             eng_start, eng_busy, eng_done;
  logic [7:0]       eng_crc;
  logic             crc_bad;
  logic [ST_W-1:0]  cause, sts_d;
  logic             shut_lat, lat_d;

  tia_thermal #(
    .TEMP_W (TEMP_W),
    .WARN_C (WARN_C),
    .SHUT_C (SHUT_C),
    .REARM_C(REARM_C)
  ) u_thermal (
    .clk        (clk),
    .rst        (rst),
    .temp_c     (temp_c),
    .warn_hot   (warn_hot),
    .shut_hot   (shut_hot),
    .cool_enough(cool_enough)
  );

  tia_crc_engine #(.NUM_BYTES(NUM_BYTES)) u_engine (
    .clk  (clk),
    .rst  (rst),
    .start(eng_start),
    .vec  (regs_flat),
    .busy (eng_busy),
    .done (eng_done),
    .crc  (eng_crc)
  );

  tia_crc_sched #(.CHECK_PERIOD(CHECK_PERIOD)) u_sched (
    .clk         (clk),
    .rst         (rst),
    .reg_wr_done (reg_wr_done),
    .eng_busy    (eng_busy),
    .eng_done    (eng_done),
    .eng_crc     (eng_crc),
    .start       (eng_start),
    .crc_mismatch(crc_bad)
  );

  always_comb begin
    cause          = '0;
    cause[ST_WARN] = warn_hot;
    cause[ST_SHUT] = shut_hot;
    cause[ST_CRC]  = crc_bad;
    sts_d          = cause | (status_q & ~{ST_W{stat_rd}});
    lat_d          = shut_hot | (shut_lat & ~(!status_q[ST_SHUT] && cool_enough));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      alarm_n  <= 1'b1;
      shut_lat <= 1'b0;
    end else begin
      status_q <= sts_d;
      alarm_n  <= ~(|sts_d);
      shut_lat <= lat_d;
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_off
    assign force_off[ch] = shut_lat;
  end

  // R5: the pin mirrors the OR of the sticky bits
  a_r5_alarm_is_or: assert property (@(posedge clk) disable iff (rst)
    alarm_n == !(|status_q));

  // R2: a shutdown status always comes with every channel forced off
  a_r2_shut_forces_off: assert property (@(posedge clk) disable iff (rst)
    status_q[ST_SHUT] |-> (&force_off));

  // R4: a warm die keeps the warning bit set through any read
  a_r4_warn_sticks: assert property (@(posedge clk) disable iff (rst)
    warn_hot |=> status_q[ST_WARN]);

  // R3: release only after cooling and a cleared shutdown bit
  a_r3_release_rule: assert property (@(posedge clk) disable iff (rst)
    $fell(force_off[0]) |-> ($past(cool_enough) && !$past(status_q[ST_SHUT])));

  // R8: a standing mismatch keeps the CRC bit set
  a_r8_crc_sticks: assert property (@(posedge clk) disable iff (rst)
    crc_bad |=> status_q[ST_CRC]);

endmodule

// File: tb/thermal_integrity_alarm_bench.sv
`timescale 1ns/1ps
module thermal_integrity_alarm_bench;

  localparam int TEMP_W = 8;
  localparam int NCH    = 6;
  localparam int NB     = 8;
  localparam int PERIOD = 1024;
  localparam int VW     = NB * 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [7:0]    temp_c = 8'd25;
  logic [VW-1:0] regs_flat = 64'h0123_4567_89AB_CDEF;
  logic          reg_wr_done = 1'b0;
  logic          stat_rd = 1'b0;
  logic [2:0]    status_q;
  logic          alarm_n;
  logic [NCH-1:0] force_off;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  thermal_integrity_alarm #(
    .TEMP_W(TEMP_W), .NUM_CH(NCH), .NUM_BYTES(NB), .CHECK_PERIOD(PERIOD)
  ) u_thermal_integrity_alarm (
    .clk(clk), .rst(rst), .temp_c(temp_c), .regs_flat(regs_flat),
    .reg_wr_done(reg_wr_done), .stat_rd(stat_rd),
    .status_q(status_q), .alarm_n(alarm_n), .force_off(force_off)
  );

  // Reference model of the thermal status bits and the shutdown latch
  logic [7:0] m_tq;
  logic m_warn, m_shut, m_lat;
  always @(posedge clk) begin
    if (rst) begin
      m_tq <= 8'd0; m_warn <= 1'b0; m_shut <= 1'b0; m_lat <= 1'b0;
    end else begin
      m_tq   <= temp_c;
      m_warn <= (m_tq >= 8'd125) | (m_warn & ~stat_rd);
      m_shut <= (m_tq >= 8'd150) | (m_shut & ~stat_rd);
      m_lat  <= (m_tq >= 8'd150) | (m_lat & ~(!m_shut && (m_tq < 8'd140)));
    end
  end

  function automatic logic [7:0] ref_crc(input logic [VW-1:0] v);
    logic [7:0] c = 8'h00;
    for (int b = 0; b < NB; b++) begin
      c = c ^ v[b*8 +: 8];
      for (int k = 0; k < 8; k++) c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
    end
    return c;
  endfunction

  function automatic logic [VW-1:0] collide(input logic [VW-1:0] v);
    logic [VW-1:0] w;
    for (int b = 0; b < 256; b++) begin
      w = v;
      w[7:0]  = w[7:0] ^ 8'h5A;
      w[15:8] = 8'(b);
      if (ref_crc(w) == ref_crc(v)) return w;
    end
    return v;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic read_status();
    stat_rd = 1'b1; step(1); stat_rd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [VW-1:0] alt_regs, bad_regs;
    int waited;
    void'($urandom(32'd7));
    step(4);
    rst = 1'b0;
    step(1);
    check(status_q == 3'b000, "R9 status after reset", status_q, 0);
    check(alarm_n == 1'b1, "R9 alarm after reset", alarm_n, 1);
    check(force_off == '0, "R9 force_off after reset", force_off, 0);

    // R1 boundary
    temp_c = 8'd124; step(3);
    check(status_q == 3'b000, "R1 no warn at 124", status_q, 0);
    temp_c = 8'd125; step(1);
    check(status_q[0] == 1'b0, "R1 not yet after one edge", status_q, 0);
    step(1);
    check(status_q[0] == 1'b1, "R1 warn at 125", status_q, 1);
    check(alarm_n == 1'b0, "R5 alarm low on warn", alarm_n, 0);
    read_status();
    check(status_q[0] == 1'b1, "R4 read cannot clear live cause", status_q, 1);
    temp_c = 8'd100; step(3);
    check(status_q[0] == 1'b1, "R4 sticky without read", status_q, 1);
    read_status();
    check(status_q == 3'b000, "R4 read clears stale bit", status_q, 0);
    check(alarm_n == 1'b1, "R5 alarm released", alarm_n, 1);

    // R2 and R3
    temp_c = 8'd150; step(2);
    check(status_q[1] == 1'b1, "R2 shutdown bit at 150", status_q, 3);
    check(force_off == {NCH{1'b1}}, "R2 all channels forced off", force_off, 6'h3F);
    temp_c = 8'd145; step(2);
    read_status();
    check(status_q[1] == 1'b0, "R3 shutdown bit cleared at 145", status_q, 1);
    step(3);
    check(force_off == {NCH{1'b1}}, "R3 held at 145 after clear", force_off, 6'h3F);
    temp_c = 8'd140; step(3);
    check(force_off == {NCH{1'b1}}, "R3 held at 140", force_off, 6'h3F);
    temp_c = 8'd139; step(2);
    check(force_off == '0, "R3 released at 139", force_off, 0);
    read_status();

    temp_c = 8'd155; step(2);
    temp_c = 8'd120; step(4);
    check(force_off == {NCH{1'b1}}, "R3 held cool until read", force_off, 6'h3F);
    read_status();
    check(force_off == {NCH{1'b1}}, "R3 still held on read edge", force_off, 6'h3F);
    step(1);
    check(force_off == '0, "R3 released after read", force_off, 0);
    temp_c = 8'd25; step(2); read_status(); step(1);

    // Random walk against the model
    for (int i = 0; i < 2000; i++) begin
      temp_c  = 8'($urandom_range(110, 165));
      stat_rd = ($urandom_range(0, 3) == 0);
      step(1);
      check(status_q[1:0] == {m_shut, m_warn}, "R4 random status", status_q, {m_shut, m_warn});
      check(force_off == {NCH{m_lat}}, "R3 random force_off", force_off, {NCH{m_lat}});
      check(alarm_n == !(m_shut | m_warn), "R5 random alarm", alarm_n, !(m_shut | m_warn));
      check(status_q[2] == 1'b0, "R7 no CRC fault on stable regs", status_q, 0);
    end
    stat_rd = 1'b0;
    temp_c = 8'd25; step(2); read_status(); step(1);
    check(status_q == 3'b000, "R4 clean before CRC tests", status_q, 0);

    // R6 written change
    alt_regs = 64'hDEAD_BEEF_5A5A_0F0F;
    regs_flat = alt_regs; reg_wr_done = 1'b1; step(1); reg_wr_done = 1'b0;
    step(2 * PERIOD + 20);
    check(status_q[2] == 1'b0, "R6 written change is not a fault", status_q, 0);

    // R7 collision
    regs_flat = collide(alt_regs);
    check(regs_flat != alt_regs, "R7 collision vector found", 0, 1);
    step(2 * PERIOD + 20);
    check(status_q[2] == 1'b0, "R7 equal CRC raises no fault", status_q, 0);

    // R7 single-bit corruption
    bad_regs = alt_regs ^ (64'd1 << 37);
    regs_flat = bad_regs;
    waited = 0;
    while (status_q[2] == 1'b0 && waited < PERIOD + NB + 8) begin
      step(1); waited++;
    end
    check(status_q[2] == 1'b1, "R7 flipped bit detected in time", waited, PERIOD + NB + 8);
    check(alarm_n == 1'b0, "R5 alarm on CRC fault", alarm_n, 0);

    // R8
    read_status(); step(1);
    check(status_q[2] == 1'b1, "R8 read cannot clear standing mismatch", status_q, 4);
    regs_flat = alt_regs;
    step(PERIOD + NB + 8);
    check(status_q[2] == 1'b1, "R8 bit sticky after match", status_q, 4);
    read_status();
    check(status_q == 3'b000, "R8 cleared after matching pass", status_q, 0);
    check(alarm_n == 1'b1, "R5 alarm released after CRC", alarm_n, 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule